// File: doc/BRIEF.md
# Ring Node Channel Dispatcher

This block sits inside a node on a control ring. It accepts one command payload at a time from the node's frame receiver. Each payload carries a channel number, a command, a transaction tag, an address and a data word. The dispatcher maps the channel number onto one of the node's local channel ports and hands the command to that port with a one-cycle request strobe. When the channel reports completion, the dispatcher builds a reply for the ring transmitter that is addressed to the ring master and echoes the transaction tag. A write produces an acknowledge reply. A read produces a reply that carries the returned data.

Channel numbers fall into fixed classes. Number 0 is the node's own controller. Numbers 1–15 are serial-bus channels, 16–31 are memory channels, 32–47 are parallel I/O and 48–63 are event-memory channels. Parameters choose how many channels of each class exist. Any other number produces an error reply instead of a request. Each channel may hold only one open transaction. Replies wait in a small FIFO in the order they complete.

Top module: `chan_dispatch`

## Requirements
- R1: An accepted payload for an implemented channel produces, in the cycle after acceptance, a single-cycle `chReq` bit on that channel's port, with `chCmd`, `chAddr` and `chData` carrying the payload fields. The port index is 0 for channel 0 and c for channel c in 1..NUM_I2C. It is 1+NUM_I2C+(c-16) for c in 16..16+NUM_MEM-1, 1+NUM_I2C+NUM_MEM+(c-32) for c in 32..32+NUM_PIO-1, and 1+NUM_I2C+NUM_MEM+NUM_PIO+(c-48) for c in 48..48+NUM_EVT-1.
- R2: When a write command (command bit 0 = 0) completes, the reply has kind 0 (acknowledge), echoes the channel number and the transaction tag, and has data zero.
- R3: When a read command (command bit 0 = 1) completes, the reply has kind 1 (read data), echoes the channel number and the transaction tag, and carries the channel's response data.
- R4: Every reply has destination 0x00 and source equal to the NODE_ADDR parameter.
- R5: A payload whose channel number is above 63, or that names a channel not implemented in its class, raises no `chReq`. It yields a reply of kind 2 (error) that echoes the channel number and the tag, with data zero.
- R6: While a channel has an open transaction, a payload for that channel is held with `inReady` low. It is accepted no earlier than the cycle after that channel's reply enters the queue. Payloads for other channels are not held.
- R7: Replies leave in the order they entered the queue. If several channels offer a response in the same cycle, the lowest port index is queued first.
- R8: One reply enters the queue per cycle. In a cycle where a channel response is being queued, an error payload is held with `inReady` low, and it is queued later.
- R9: While `repValid` is high and `repReady` is low, all reply fields stay stable. While the queue is full, `chRespReady` stays low.
- R10: After reset `repValid`, `chReq` and `chRespReady` are low and no channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload present |
| inReady | output | 1 | Payload accepted this cycle when high with inValid |
| inChan | input | 8 | Channel number |
| inCmd | input | 8 | Command, bit 0 selects read |
| inTrn | input | 8 | Transaction tag |
| inAddr | input | AW | Channel address |
| inData | input | DW | Data word |
| chReq | output | NCH | One-cycle request strobe per channel port |
| chCmd | output | 8 | Command for the strobed channel |
| chAddr | output | AW | Address for the strobed channel |
| chData | output | DW | Data for the strobed channel |
| chRespValid | input | NCH | Channel has finished and offers a response |
| chRespReady | output | NCH | Response taken this cycle |
| chRespData | input | NCH*DW | Read data per channel, port i at bits i*DW +: DW |
| repValid | output | 1 | Reply at queue head |
| repReady | input | 1 | Transmitter takes the reply |
| repDest | output | 8 | Reply destination node |
| repSrc | output | 8 | Reply source node |
| repKind | output | 2 | 0 acknowledge, 1 read data, 2 error |
| repChan | output | 8 | Echoed channel number |
| repTrn | output | 8 | Echoed transaction tag |
| repData | output | DW | Reply data |

## Verification
Completing a channel response and turning an unroutable payload into an error reply both need the single queue write port, so they can fall on the same cycle. The bench provokes this by presenting a bad channel number on the exact cycle a channel's response is raised, after counting that channel's latency from its request strobe. It then requires `inReady` to be low in that cycle, and it requires the channel reply to come out first with the error reply after it, both with their own tags.

// File: rtl/chan_dispatch_pkg.sv
package chan_dispatch_pkg;

  typedef enum logic [1:0] {
    KIND_WACK  = 2'd0,
    KIND_RDATA = 2'd1,
    KIND_ERR   = 2'd2
  } repKind_e;

  // strobes from control to datapath; port indices fit six bits (at most 64 ports)
  typedef struct packed {
    logic       capture;
    logic [5:0] capIdx;
    logic       pushChan;
    logic [5:0] grantIdx;
    logic       pushErr;
    logic       pop;
  } dispStrobe_t;

endpackage

// File: rtl/chan_dispatch_ctrl.sv
module chan_dispatch_ctrl
  import chan_dispatch_pkg::*;
#(
  parameter int NUM_I2C = 3,
  parameter int NUM_MEM = 2,
  parameter int NUM_PIO = 1,
  parameter int NUM_EVT = 1,
  localparam int NCH = 1 + NUM_I2C + NUM_MEM + NUM_PIO + NUM_EVT
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [7:0]     inChan,
  output logic           inReady,
  input  logic [NCH-1:0] chRespValid,
  output logic [NCH-1:0] chRespReady,
  output logic [NCH-1:0] chReq,
  input  logic           fifoFull,
  input  logic           repValid,
  input  logic           repReady,
  output dispStrobe_t    strb
);

  localparam int MEM_BASE = 1 + NUM_I2C;
  localparam int PIO_BASE = MEM_BASE + NUM_MEM;
  localparam int EVT_BASE = PIO_BASE + NUM_PIO;

  logic [NCH-1:0] busy;
  logic           decHit;
  logic [5:0]     decIdx;
  logic           busyHit;
  logic           grantValid;
  logic [5:0]     grantIdx;
  logic           pushChan;
  logic           pushErr;
  logic           capture;

  // channel number to port index
  always_comb begin
    decHit = 1'b0;
    decIdx = '0;
    if (inChan == 8'd0) begin
      decHit = 1'b1;
    end else if (inChan <= 8'(NUM_I2C)) begin
      decHit = 1'b1;
      decIdx = 6'(inChan);
    end else if (inChan >= 8'd16 && inChan < 8'(16 + NUM_MEM)) begin
      decHit = 1'b1;
      decIdx = 6'(MEM_BASE) + 6'(inChan - 8'd16);
    end else if (inChan >= 8'd32 && inChan < 8'(32 + NUM_PIO)) begin
      decHit = 1'b1;
      decIdx = 6'(PIO_BASE) + 6'(inChan - 8'd32);
    end else if (inChan >= 8'd48 && inChan < 8'(48 + NUM_EVT)) begin
      decHit = 1'b1;
      decIdx = 6'(EVT_BASE) + 6'(inChan - 8'd48);
    end
  end

  always_comb begin
    busyHit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (decIdx == 6'(i)) busyHit = busy[i];
    end
  end

  // fixed priority, lowest port first
  always_comb begin
    grantValid = 1'b0;
    grantIdx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (chRespValid[i] && busy[i]) begin
        grantValid = 1'b1;
        grantIdx   = 6'(i);
      end
    end
  end

  assign pushChan = grantValid && !fifoFull;
  assign capture  = inValid && decHit && !busyHit;
  assign pushErr  = inValid && !decHit && !pushChan && !fifoFull;
  assign inReady  = decHit ? !busyHit : (!pushChan && !fifoFull);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      chRespReady[i] = pushChan && (grantIdx == 6'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= '0;
      chReq <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        chReq[i] <= capture && (decIdx == 6'(i));
        if (capture && (decIdx == 6'(i))) busy[i] <= 1'b1;
        else if (chRespReady[i])           busy[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.capture  = capture;
    strb.capIdx   = decIdx;
    strb.pushChan = pushChan;
    strb.grantIdx = grantIdx;
    strb.pushErr  = pushErr;
    strb.pop      = repValid && repReady;
  end

  // R1
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chReq));

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chRespReady));

  // R8
  collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chRespReady) |-> !(inValid && inReady && !decHit));

  // R9
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> (chRespReady == '0));

  for (genvar g = 0; g < NCH; g++) begin : gBusyChk
    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busy[g] && !chRespReady[g]) |=> !chReq[g]);
  end

endmodule

// File: rtl/chan_dispatch_dp.sv
module chan_dispatch_dp
  import chan_dispatch_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dispStrobe_t       strb,
  input  logic [7:0]        inChan,
  input  logic [7:0]        inCmd,
  input  logic [7:0]        inTrn,
  input  logic [AW-1:0]     inAddr,
  input  logic [DW-1:0]     inData,
  input  logic [NCH*DW-1:0] chRespData,
  output logic [7:0]        chCmd,
  output logic [AW-1:0]     chAddr,
  output logic [DW-1:0]     chData,
  output logic              fifoFull,
  output logic              repValid,
  output logic [1:0]        repKind,
  output logic [7:0]        repChan,
  output logic [7:0]        repTrn,
  output logic [DW-1:0]     repData
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]     openChan [NCH];
  logic [7:0]     openTrn  [NCH];
  logic [NCH-1:0] openRead;

  logic [1:0]     qKind [DEPTH];
  logic [7:0]     qChan [DEPTH];
  logic [7:0]     qTrn  [DEPTH];
  logic [DW-1:0]  qData [DEPTH];
  logic [PW-1:0]  wrPtr, rdPtr;
  logic [CW-1:0]  cnt;

  repKind_e       newKind;
  logic [7:0]     newChan, newTrn;
  logic [DW-1:0]  newData;
  logic           push;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  // per-channel open transaction record and shared request bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chCmd    <= '0;
      chAddr   <= '0;
      chData   <= '0;
      openRead <= '0;
    end else if (strb.capture) begin
      chCmd  <= inCmd;
      chAddr <= inAddr;
      chData <= inData;
      for (int i = 0; i < NCH; i++) begin
        if (strb.capIdx == 6'(i)) begin
          openChan[i] <= inChan;
          openTrn[i]  <= inTrn;
          openRead[i] <= inCmd[0];
        end
      end
    end
  end

  // reply assembly
  always_comb begin
    newKind = KIND_ERR;
    newChan = inChan;
    newTrn  = inTrn;
    newData = '0;
    if (strb.pushChan) begin
      for (int i = 0; i < NCH; i++) begin
        if (strb.grantIdx == 6'(i)) begin
          newChan = openChan[i];
          newTrn  = openTrn[i];
          newKind = openRead[i] ? KIND_RDATA : KIND_WACK;
          newData = openRead[i] ? chRespData[i*DW +: DW] : '0;
        end
      end
    end
  end

  assign push = strb.pushChan || strb.pushErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) begin
        qKind[wrPtr] <= newKind;
        qChan[wrPtr] <= newChan;
        qTrn[wrPtr]  <= newTrn;
        qData[wrPtr] <= newData;
        wrPtr        <= bump(wrPtr);
      end
      if (strb.pop) rdPtr <= bump(rdPtr);
      if (push && !strb.pop)      cnt <= cnt + 1'b1;
      else if (strb.pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assign fifoFull = (cnt == CW'(DEPTH));
  assign repValid = (cnt != '0);
  assign repKind  = qKind[rdPtr];
  assign repChan  = qChan[rdPtr];
  assign repTrn   = qTrn[rdPtr];
  assign repData  = qData[rdPtr];

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !fifoFull);

  // R8
  single_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pushChan && strb.pushErr));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (repValid && !strb.pop) |=> (repValid && $stable(repKind) && $stable(repChan)
                                 && $stable(repTrn) && $stable(repData)));

  // R2
  ack_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (repValid && repKind == 2'd0) |-> (repData == '0));

endmodule

// File: rtl/chan_dispatch.sv
module chan_dispatch
  import chan_dispatch_pkg::*;
#(
  parameter int         NUM_I2C   = 3,
  parameter int         NUM_MEM   = 2,
  parameter int         NUM_PIO   = 1,
  parameter int         NUM_EVT   = 1,
  parameter int         DW        = 16,
  parameter int         AW        = 8,
  parameter int         DEPTH     = 4,
  parameter logic [7:0] NODE_ADDR = 8'h05,
  localparam int NCH = 1 + NUM_I2C + NUM_MEM + NUM_PIO + NUM_EVT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inChan,
  input  logic [7:0]        inCmd,
  input  logic [7:0]        inTrn,
  input  logic [AW-1:0]     inAddr,
  input  logic [DW-1:0]     inData,
  output logic [NCH-1:0]    chReq,
  output logic [7:0]        chCmd,
  output logic [AW-1:0]     chAddr,
  output logic [DW-1:0]     chData,
  input  logic [NCH-1:0]    chRespValid,
  output logic [NCH-1:0]    chRespReady,
  input  logic [NCH*DW-1:0] chRespData,
  output logic              repValid,
  input  logic              repReady,
  output logic [7:0]        repDest,
  output logic [7:0]        repSrc,
  output logic [1:0]        repKind,
  output logic [7:0]        repChan,
  output logic [7:0]        repTrn,
  output logic [DW-1:0]     repData
);

  dispStrobe_t strb;
  logic        fifoFull;

  chan_dispatch_ctrl #(
    .NUM_I2C(NUM_I2C), .NUM_MEM(NUM_MEM), .NUM_PIO(NUM_PIO), .NUM_EVT(NUM_EVT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan), .inReady(inReady),
    .chRespValid(chRespValid), .chRespReady(chRespReady), .chReq(chReq),
    .fifoFull(fifoFull), .repValid(repValid), .repReady(repReady), .strb(strb)
  );

  chan_dispatch_dp #(
    .NCH(NCH), .DW(DW), .AW(AW), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inChan(inChan), .inCmd(inCmd),
    .inTrn(inTrn), .inAddr(inAddr), .inData(inData), .chRespData(chRespData),
    .chCmd(chCmd), .chAddr(chAddr), .chData(chData), .fifoFull(fifoFull),
    .repValid(repValid), .repKind(repKind), .repChan(repChan), .repTrn(repTrn),
    .repData(repData)
  );

  assign repDest = 8'h00;
  assign repSrc  = NODE_ADDR;

endmodule

// File: tb/chan_dispatch_bench.sv
`timescale 1ns/1ps
module chan_dispatch_bench;

  localparam int NI = 3, NM = 2, NP = 1, NE = 1;
  localparam int NCH = 1 + NI + NM + NP + NE;
  localparam int DW = 16, AW = 8, DEPTH = 4;
  localparam logic [7:0] NODE = 8'h05;

  typedef struct packed {
    logic [1:0]    kind;
    logic [7:0]    chan;
    logic [7:0]    trn;
    logic [DW-1:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inChan = '0, inCmd = '0, inTrn = '0;
  logic [AW-1:0] inAddr = '0;
  logic [DW-1:0] inData = '0;
  logic repReady = 1'b1;
  logic inReady, repValid;
  logic [NCH-1:0] chReq, chRespReady;
  logic [7:0] chCmd, repDest, repSrc, repChan, repTrn;
  logic [AW-1:0] chAddr;
  logic [DW-1:0] chData, repData;
  logic [1:0] repKind;
  wire  [NCH-1:0] chRespValid;
  wire  [NCH*DW-1:0] chRespData;

  int checks = 0;
  int fails = 0;
  exp_t expQ[$];
  int lat [NCH];
  logic [7:0] expTrn [NCH];
  logic [7:0] expChan [NCH];
  time accTime = 0;

  always #2.5 clk = ~clk;

  chan_dispatch #(
    .NUM_I2C(NI), .NUM_MEM(NM), .NUM_PIO(NP), .NUM_EVT(NE),
    .DW(DW), .AW(AW), .DEPTH(DEPTH), .NODE_ADDR(NODE)
  ) u_chan_dispatch (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inChan(inChan), .inCmd(inCmd), .inTrn(inTrn), .inAddr(inAddr), .inData(inData),
    .chReq(chReq), .chCmd(chCmd), .chAddr(chAddr), .chData(chData),
    .chRespValid(chRespValid), .chRespReady(chRespReady), .chRespData(chRespData),
    .repValid(repValid), .repReady(repReady), .repDest(repDest), .repSrc(repSrc),
    .repKind(repKind), .repChan(repChan), .repTrn(repTrn), .repData(repData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic int idxOf(input logic [7:0] ch);
    if (ch == 8'd0) return 0;
    if (ch >= 8'd1 && ch <= 8'(NI)) return int'(ch);
    if (ch >= 8'd16 && ch < 8'(16 + NM)) return 1 + NI + int'(ch) - 16;
    if (ch >= 8'd32 && ch < 8'(32 + NP)) return 1 + NI + NM + int'(ch) - 32;
    if (ch >= 8'd48 && ch < 8'(48 + NE)) return 1 + NI + NM + NP + int'(ch) - 48;
    return -1;
  endfunction

  // channel models: respond after lat cycles, push expected reply on handshake
  for (genvar i = 0; i < NCH; i++) begin : chm
    logic rv = 1'b0;
    logic [DW-1:0] rd = '0;
    time ct = 0;
    assign chRespValid[i] = rv;
    assign chRespData[i*DW +: DW] = rd;
    initial begin
      logic isRd;
      logic [AW-1:0] a;
      forever begin
        @(negedge clk);
        if (chReq[i]) begin
          isRd = chCmd[0];
          a = chAddr;
          repeat (lat[i]) @(negedge clk);
          rv = 1'b1;
          rd = isRd ? ({a, 8'(i)} ^ 16'h5A00) : 16'hDEAD;
          forever begin
            #1;
            if (chRespReady[i]) break;
            @(negedge clk);
          end
          ct = $time;
          expQ.push_back('{kind: isRd ? 2'd1 : 2'd0, chan: expChan[i], trn: expTrn[i],
                           data: isRd ? rd : '0});
          @(negedge clk);
          rv = 1'b0;
        end
      end
    end
  end

  // monitor: pop expected reply as each reply leaves
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (repValid && repReady) begin
        chk(repDest == 8'h00 && repSrc == NODE, "R4", "reply addressing",
            {16'h0, repDest, repSrc}, {16'h0, 8'h00, NODE});
        if (expQ.size() == 0) begin
          chk(1'b0, "R7", "unexpected reply tag", {24'h0, repTrn}, 32'h0);
        end else begin
          e = expQ.pop_front();
          chk(repKind == e.kind && repChan == e.chan && repTrn == e.trn && repData == e.data,
              (e.kind == 2'd0) ? "R2" : (e.kind == 2'd1) ? "R3" : "R5",
              "reply kind/chan/trn/data",
              {repKind[1:0], 6'h0, repTrn, repData}, {e.kind, 6'h0, e.trn, e.data});
        end
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog expired: actual hung, expected all replies");
    finishRun();
  end

  // drive one payload, starting at a falling edge
  task automatic sendCore(input logic [7:0] ch, input logic [7:0] cmd, input logic [7:0] trn,
                          input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expStall);
    int idx;
    bit acc;
    bit first;
    idx = idxOf(ch);
    acc = 1'b0;
    first = 1'b1;
    inValid = 1'b1; inChan = ch; inCmd = cmd; inTrn = trn; inAddr = a; inData = d;
    while (!acc) begin
      #1;
      if (first && expStall)
        chk(!inReady, "R8", "error payload stalled during channel queueing",
            {31'h0, inReady}, 32'h0);
      first = 1'b0;
      if (inReady) acc = 1'b1;
      else @(negedge clk);
    end
    accTime = $time;
    if (idx >= 0) begin
      expTrn[idx] = trn;
      expChan[idx] = ch;
    end else begin
      expQ.push_back('{kind: 2'd2, chan: ch, trn: trn, data: '0});
    end
    @(negedge clk);
    inValid = 1'b0;
    #1;
    if (idx >= 0)
      chk(chReq == (NCH'(1) << idx) && chCmd == cmd && chAddr == a && chData == d,
          "R1", "request strobe and bus", {24'h0, chReq}, {24'h0, NCH'(1) << idx});
    else
      chk(chReq == '0, "R5", "no request for bad channel", {24'h0, chReq}, 32'h0);
  endtask

  task automatic send(input logic [7:0] ch, input logic [7:0] cmd, input logic [7:0] trn,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    sendCore(ch, cmd, trn, a, d, 1'b0);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] headTrn;
    for (int i = 0; i < NCH; i++) begin
      lat[i] = 1;
      expTrn[i] = '0;
      expChan[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R10
    chk(repValid == 1'b0 && chReq == '0 && chRespReady == '0, "R10", "reset outputs",
        {23'h0, repValid, chReq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(inReady == 1'b1, "R10", "ready after reset", {31'h0, inReady}, 32'h1);

    // writes across every class (R1, R2)
    send(8'd0,  8'h00, 8'h10, 8'h01, 16'h1111);
    send(8'd2,  8'h02, 8'h11, 8'h22, 16'h2222);
    send(8'd17, 8'h00, 8'h12, 8'h33, 16'h3333);
    send(8'd32, 8'h00, 8'h13, 8'h44, 16'h4444);
    send(8'd48, 8'h04, 8'h14, 8'h55, 16'h5555);
    drain();

    // reads (R3)
    send(8'd1,  8'h01, 8'h20, 8'h66, 16'h0);
    send(8'd16, 8'h01, 8'h21, 8'h77, 16'h0);
    send(8'd48, 8'h03, 8'h22, 8'h88, 16'h0);
    send(8'd3,  8'h01, 8'h23, 8'h99, 16'h0);
    drain();

    // errors (R5)
    send(8'd70, 8'h00, 8'h30, 8'h00, 16'h0);
    send(8'd5,  8'h01, 8'h31, 8'h00, 16'h0);
    send(8'd20, 8'h00, 8'h32, 8'h00, 16'h0);
    send(8'd33, 8'h01, 8'h33, 8'h00, 16'h0);
    send(8'd49, 8'h00, 8'h34, 8'h00, 16'h0);
    send(8'd63, 8'h00, 8'h35, 8'h00, 16'h0);
    send(8'hFF, 8'h01, 8'h36, 8'h00, 16'h0);
    send(8'd15, 8'h00, 8'h37, 8'h00, 16'h0);
    drain();

    // busy channel held, other channel passes (R6, R7)
    lat[1] = 15;
    send(8'd1, 8'h00, 8'h40, 8'h10, 16'hAAAA);
    lat[2] = 1;
    send(8'd2, 8'h01, 8'h42, 8'h12, 16'h0);
    lat[1] = 2;
    send(8'd1, 8'h01, 8'h41, 8'h11, 16'h0);
    // R6
    chk(accTime > chm[1].ct, "R6", "busy channel accepted after its reply",
        32'(accTime), 32'(chm[1].ct));
    drain();

    // full queue and simultaneous responses (R9, R7)
    for (int i = 0; i < NCH; i++) lat[i] = 0;
    @(negedge clk);
    repReady = 1'b0;
    send(8'd0,  8'h00, 8'h50, 8'h01, 16'h0);
    send(8'd2,  8'h00, 8'h51, 8'h02, 16'h0);
    send(8'd16, 8'h00, 8'h52, 8'h03, 16'h0);
    send(8'd32, 8'h00, 8'h53, 8'h04, 16'h0);
    repeat (4) @(negedge clk);
    send(8'd3, 8'h01, 8'h54, 8'h05, 16'h0);
    send(8'd1, 8'h01, 8'h55, 8'h06, 16'h0);
    repeat (3) @(negedge clk);
    #1;
    // R9
    chk(chRespReady == '0 && chRespValid[1] && chRespValid[3], "R9",
        "responses stalled while queue full", {24'h0, chRespReady}, 32'h0);
    headTrn = repTrn;
    @(negedge clk);
    #1;
    chk(repValid && repTrn == headTrn, "R9", "head stable under backpressure",
        {24'h0, repTrn}, {24'h0, headTrn});
    @(negedge clk);
    repReady = 1'b1;
    drain();
    // R7
    chk(chm[1].ct < chm[3].ct, "R7", "lower port queued first on tie",
        32'(chm[1].ct), 32'(chm[3].ct));

    // error payload colliding with a channel completion (R8)
    lat[1] = 4;
    send(8'd1, 8'h00, 8'h60, 8'h07, 16'h0);
    repeat (4) @(negedge clk);
    sendCore(8'd99, 8'h00, 8'h61, 8'h00, 16'h0, 1'b1);
    drain();

    repeat (5) @(negedge clk);
    #1;
    chk(expQ.size() == 0 && !repValid, "R7", "all replies delivered",
        32'(expQ.size()), 32'h0);
    finishRun();
  end

endmodule